// File: doc/BRIEF.md
# Z80 Memory and I/O Decode Glue

This block sits between a Z80-style processor bus and the memories and peripherals of a small computer. From the address bus and the memory, I/O, read, write and opcode-fetch strobes it produces the ROM and RAM chip selects. It also produces two levels of active-low I/O selects: eight selects of 32 ports each, and eight selects of 4 ports each inside the lowest group. It also answers reads of the configuration port with the value of an 8-position switch bank.

At reset the low half of memory is served by ROM and the high half by RAM. Boot code removes the ROM from the map by writing any value to the configuration port group. From then on the whole 64K space selects RAM. Software cannot undo this. Only the reset input brings the ROM back. A status output shows whether the ROM is currently mapped.

Top module: `z80_bus_glue`

## Requirements
- R1: While `rst_n` is low and after it is released, `rom_map_on` is 1. A memory read (`mreq_n`=0, `wr_n`=1) with `addr[15]`=0 drives `rom_cs_n`=0 and `ram_cs_n`=1. A memory access with `addr[15]`=1 drives `ram_cs_n`=0 and `rom_cs_n`=1.
- R2: An I/O write (`iorq_n`=0, `m1_n`=1, `wr_n`=0) with `addr[7:2]`=0 unmaps the ROM whatever the data. On the first rising clock edge at which `wr_n` is sampled high after such a write was sampled, `rom_map_on` goes to 0. After that every memory access drives `ram_cs_n`=0 and `rom_cs_n`=1.
- R3: Once unmapped, the ROM stays unmapped under any bus activity. Only `rst_n`=0 sets `rom_map_on` back to 1.
- R4: During an I/O cycle (`iorq_n`=0, `m1_n`=1), `grp_sel_n[n]` is 0 exactly when `addr[7:5]`=n. Outside I/O cycles every bit is 1.
- R5: During an I/O cycle, `quad_sel_n[k]` is 0 exactly when `addr[7:2]`=k. For ports 32 and up, all bits are 1.
- R6: `addr[15:8]` has no effect on any I/O select or on the configuration port decode.
- R7: An interrupt acknowledge (`iorq_n`=0, `m1_n`=0) asserts no I/O select, does not enable the data output, and does not unmap the ROM even if `wr_n` and `addr[7:2]`=0 are present.
- R8: Both memory selects are 1 while `mreq_n`=1. `rom_cs_n` is never 0 when `wr_n`=0. A memory write to `addr[15]`=0 while the ROM is mapped selects neither memory.
- R9: An I/O read (`iorq_n`=0, `m1_n`=1, `rd_n`=0) with `addr[7:2]`=0 sets `cfg_oe`=1. `cfg_dout` then carries `cfg_sw` as sampled two rising edges earlier. A closed switch reads 0 and an open switch reads 1, and the synchronizer resets to all ones. At all other times `cfg_oe`=0 and `cfg_dout`=0.
- R10: `rom_map_on` always equals the current map state used by the memory selects.
- R11: I/O writes to any port outside 0 to 3 leave the ROM mapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Address bus |
| mreq_n | input | 1 | Memory request strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch / acknowledge marker, active low |
| cfg_sw | input | 8 | Configuration switches, open = 1 |
| rom_cs_n | output | 1 | ROM chip select, active low |
| ram_cs_n | output | 1 | RAM chip select, active low |
| grp_sel_n | output | 8 | 32-port group selects, active low |
| quad_sel_n | output | 8 | 4-port selects within group 0, active low |
| cfg_dout | output | 8 | Switch value for the data bus |
| cfg_oe | output | 1 | Data bus drive enable for `cfg_dout` |
| rom_map_on | output | 1 | 1 while the ROM overlay is mapped |

## Verification
The hardest cases to reach are those where the map must not change. These are an interrupt acknowledge that carries a write strobe and a config-group address, and writes to near-miss ports such as port 4 or an address whose low byte differs from zero only in its upper bits. The bench drives these cycles while the ROM is still mapped, then reads address 0000h to show that the ROM still answers. It then unmaps the ROM, repeats config writes and acknowledges, and reads low memory again. Last it applies reset to show the overlay comes back. A behavioural model running next to the block tracks the map state and a two-deep switch history on every clock.

// File: rtl/z80_glue_pkg.sv
package z80_glue_pkg;
  // Index of the 4-port select that holds the configuration port
  localparam int unsigned CFG_QUAD = 0;

  typedef enum logic [1:0] {
    MAP_NONE = 2'd0,
    MAP_ROM  = 2'd1,
    MAP_RAM  = 2'd2
  } mem_target_e;
endpackage

// File: rtl/glue_sw_sync.sv
module glue_sw_sync #(
  parameter int unsigned SW_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SW_W-1:0] sw_in,
  output logic [SW_W-1:0] sw_out
);
  logic [SW_W-1:0] stage1_q, stage2_q;
  logic [SW_W-1:0] stage1_d, stage2_d;

  always_comb begin
    stage1_d = sw_in;
    stage2_d = stage1_q;
  end

  // Open switches read as ones, so the reset value is all ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '1;
      stage2_q <= '1;
    end else begin
      stage1_q <= stage1_d;
      stage2_q <= stage2_d;
    end
  end

  assign sw_out = stage2_q;
endmodule

// File: rtl/glue_io_decode.sv
module glue_io_decode #(
  parameter int unsigned PORT_W   = 8,
  parameter int unsigned GRP_CNT  = 8,
  parameter int unsigned QUAD_CNT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PORT_W-1:0]   port,
  input  logic                iorq_n,
  input  logic                m1_n,
  input  logic                rd_n,
  input  logic                wr_n,
  output logic [GRP_CNT-1:0]  grp_sel_n,
  output logic [QUAD_CNT-1:0] quad_sel_n,
  output logic                cfg_rd,
  output logic                cfg_wr
);
  import z80_glue_pkg::*;

  localparam int unsigned GRP_BITS  = $clog2(GRP_CNT);
  localparam int unsigned GRP_LSB   = PORT_W - GRP_BITS;
  localparam int unsigned QUAD_LSB  = 2;
  localparam int unsigned QUAD_BITS = PORT_W - QUAD_LSB;

  logic io_cyc;
  logic cfg_hit;

  // Interrupt acknowledge (M1 low together with IORQ) is not a port access
  assign io_cyc = !iorq_n && m1_n;

  for (genvar g = 0; g < GRP_CNT; g++) begin : g_grp
    localparam logic [GRP_BITS-1:0] GIDX = g;
    assign grp_sel_n[g] = !(io_cyc && (port[PORT_W-1:GRP_LSB] == GIDX));
  end

  for (genvar q = 0; q < QUAD_CNT; q++) begin : g_quad
    localparam logic [QUAD_BITS-1:0] QIDX = q;
    assign quad_sel_n[q] = !(io_cyc && (port[PORT_W-1:QUAD_LSB] == QIDX));
  end

  assign cfg_hit = !quad_sel_n[CFG_QUAD];
  assign cfg_rd  = cfg_hit && !rd_n;
  assign cfg_wr  = cfg_hit && !wr_n;

  assert_iack_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!iorq_n && !m1_n) |-> (&grp_sel_n && &quad_sel_n && !cfg_wr));
  assert_grp_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~grp_sel_n));
  assert_quad_in_grp0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (~quad_sel_n != '0) |-> !grp_sel_n[0]);
endmodule

// File: rtl/glue_overlay_latch.sv
module glue_overlay_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic wr_n,
  output logic rom_on
);
  logic seen_q, seen_d, seen_en;
  logic rom_q, rom_d, rom_en;

  // Remember a qualifying write; the map changes when WR is seen released
  always_comb begin
    seen_en = 1'b1;
    seen_d  = cfg_wr;
    rom_en  = seen_q && wr_n;
    rom_d   = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      rom_q  <= 1'b1;
    end else begin
      if (seen_en) seen_q <= seen_d;
      if (rom_en)  rom_q  <= rom_d;
    end
  end

  assign rom_on = rom_q;

  assert_one_way_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_q |=> !rom_q);
  assert_clear_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_q && !seen_q) |=> rom_q);
endmodule

// File: rtl/glue_mem_decode.sv
module glue_mem_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_hi,
  input  logic mreq_n,
  input  logic wr_n,
  input  logic rom_on,
  output logic rom_cs_n,
  output logic ram_cs_n
);
  import z80_glue_pkg::*;

  mem_target_e tgt;

  always_comb begin
    tgt = MAP_NONE;
    if (!mreq_n) begin
      if (rom_on && !addr_hi) tgt = wr_n ? MAP_ROM : MAP_NONE;
      else                    tgt = MAP_RAM;
    end
  end

  assign rom_cs_n = (tgt != MAP_ROM);
  assign ram_cs_n = (tgt != MAP_RAM);

  assert_rom_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_cs_n |-> wr_n);
  assert_cs_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rom_cs_n && !ram_cs_n));
  assert_idle_no_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_n |-> (rom_cs_n && ram_cs_n));
endmodule

// File: rtl/z80_bus_glue.sv
module z80_bus_glue #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned PORT_W   = 8,
  parameter int unsigned GRP_CNT  = 8,
  parameter int unsigned QUAD_CNT = 8,
  parameter int unsigned SW_W     = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                mreq_n,
  input  logic                iorq_n,
  input  logic                rd_n,
  input  logic                wr_n,
  input  logic                m1_n,
  input  logic [SW_W-1:0]     cfg_sw,
  output logic                rom_cs_n,
  output logic                ram_cs_n,
  output logic [GRP_CNT-1:0]  grp_sel_n,
  output logic [QUAD_CNT-1:0] quad_sel_n,
  output logic [SW_W-1:0]     cfg_dout,
  output logic                cfg_oe,
  output logic                rom_map_on
);
  logic            cfg_rd, cfg_wr, rom_on;
  logic [SW_W-1:0] sw_s;
  logic            unused_hi;

  // Upper address byte plays no part in the port decode
  assign unused_hi = ^addr[ADDR_W-2:PORT_W];

  glue_io_decode #(.PORT_W(PORT_W), .GRP_CNT(GRP_CNT), .QUAD_CNT(QUAD_CNT)) u_io (
    .clk(clk), .rst_n(rst_n), .port(addr[PORT_W-1:0]), .iorq_n(iorq_n), .m1_n(m1_n),
    .rd_n(rd_n), .wr_n(wr_n), .grp_sel_n(grp_sel_n), .quad_sel_n(quad_sel_n),
    .cfg_rd(cfg_rd), .cfg_wr(cfg_wr)
  );

  glue_overlay_latch u_ovl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .wr_n(wr_n), .rom_on(rom_on)
  );

  glue_mem_decode u_mem (
    .clk(clk), .rst_n(rst_n), .addr_hi(addr[ADDR_W-1]), .mreq_n(mreq_n), .wr_n(wr_n),
    .rom_on(rom_on), .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n)
  );

  glue_sw_sync #(.SW_W(SW_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .sw_in(cfg_sw), .sw_out(sw_s)
  );

  assign cfg_oe     = cfg_rd;
  assign cfg_dout   = cfg_rd ? sw_s : '0;
  assign rom_map_on = rom_on;

  assert_dout_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_oe |-> (cfg_dout == '0));
  assert_oe_is_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_oe |-> (!rd_n && !iorq_n && m1_n));
endmodule

// File: tb/tb_z80_bus_glue.sv
module tb_z80_bus_glue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
  logic [7:0]  cfg_sw = 8'hFF;
  logic        rom_cs_n, ram_cs_n, cfg_oe, rom_map_on;
  logic [7:0]  grp_sel_n, quad_sel_n, cfg_dout;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // Reference state
  bit  m_rom = 1'b1;
  bit  m_pend = 1'b0;
  logic [7:0] m_h1 = 8'hFF, m_h2 = 8'hFF;

  always #5 clk = ~clk;

  z80_bus_glue dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n), .cfg_sw(cfg_sw), .rom_cs_n(rom_cs_n),
    .ram_cs_n(ram_cs_n), .grp_sel_n(grp_sel_n), .quad_sel_n(quad_sel_n),
    .cfg_dout(cfg_dout), .cfg_oe(cfg_oe), .rom_map_on(rom_map_on)
  );

  always @(negedge rst_n) begin
    m_rom = 1'b1; m_pend = 1'b0; m_h1 = 8'hFF; m_h2 = 8'hFF;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rom = 1'b1; m_pend = 1'b0; m_h1 = 8'hFF; m_h2 = 8'hFF;
    end else begin
      if (m_pend && wr_n) m_rom = 1'b0;
      m_pend = !iorq_n && m1_n && !wr_n && (int'(addr[7:0]) < 4);
      m_h2 = m_h1;
      m_h1 = cfg_sw;
    end
  end

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int port;
    bit io, memlow;
    logic [7:0] e_grp, e_quad;
    port = int'(addr[7:0]);
    io = !iorq_n && m1_n;
    e_grp = 8'hFF; e_quad = 8'hFF;
    if (io) begin
      e_grp[port / 32] = 1'b0;
      if (port < 32) e_quad[port / 4] = 1'b0;
    end
    memlow = (addr < 16'h8000);
    chk("rom_map_on", {7'd0, rom_map_on}, {7'd0, m_rom});
    chk("rom_cs_n", {7'd0, rom_cs_n},
        {7'd0, !(!mreq_n && m_rom && memlow && wr_n)});
    chk("ram_cs_n", {7'd0, ram_cs_n},
        {7'd0, !(!mreq_n && !(m_rom && memlow))});
    chk("grp_sel_n", grp_sel_n, e_grp);
    chk("quad_sel_n", quad_sel_n, e_quad);
    chk("cfg_oe", {7'd0, cfg_oe}, {7'd0, io && !rd_n && port < 4});
    chk("cfg_dout", cfg_dout, (io && !rd_n && port < 4) ? m_h2 : 8'h00);
  end

  task automatic idle(input int n);
    mreq_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic mem(input logic [15:0] a, input bit wr);
    addr = a; mreq_n = 1'b0; rd_n = wr; wr_n = !wr; m1_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    idle(1);
  endtask

  task automatic io(input logic [15:0] a, input bit wr, input bit iack);
    addr = a; iorq_n = 1'b0; m1_n = iack ? 1'b0 : 1'b1;
    rd_n = wr ? 1'b1 : 1'b0; wr_n = wr ? 1'b0 : 1'b1;
    repeat (2) @(posedge clk);
    #1;
    idle(1);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2);
    mem(16'h0000, 0); mem(16'h7FFF, 0); mem(16'h8000, 0); mem(16'hFFFF, 1);
    tag = "R8";
    mem(16'h0100, 1); mem(16'h9000, 1); idle(2);
    tag = "R4";
    io(16'h0020, 0, 0); io(16'h0045, 0, 0); io(16'h00E3, 0, 0); io(16'h00FF, 1, 0);
    tag = "R5";
    io(16'h0004, 0, 0); io(16'h000B, 0, 0); io(16'h001C, 0, 0); io(16'h001F, 0, 0);
    tag = "R6";
    io(16'hAB05, 0, 0); io(16'hFF9E, 0, 0); io(16'h7F01, 0, 0);
    tag = "R9";
    cfg_sw = 8'hA5; idle(3);
    io(16'h1202, 0, 0);
    cfg_sw = 8'h3C; io(16'h0000, 0, 0); idle(2); io(16'h0003, 0, 0);
    tag = "R7";
    io(16'h0001, 1, 1); io(16'h0000, 0, 1); mem(16'h0000, 0);
    tag = "R11";
    io(16'h0104, 1, 0); io(16'h0020, 1, 0); io(16'h00E0, 1, 0); mem(16'h0000, 0);
    tag = "R2";
    io(16'hFF03, 1, 0); mem(16'h0000, 0); mem(16'h0100, 1); mem(16'hC000, 0);
    tag = "R3";
    io(16'h0000, 1, 0); io(16'h0002, 1, 1); io(16'h0001, 0, 0); mem(16'h0000, 0);
    tag = "R10";
    #2 rst_n = 1'b0;
    idle(2);
    #1 rst_n = 1'b1;
    idle(1);
    mem(16'h0000, 0); mem(16'h4000, 1); mem(16'h8001, 0);
    idle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule